// File: doc/BRIEF.md
# DMA Page Register Address Generator

This block holds the page bytes that extend a four-channel DMA controller's 16-bit address registers to a wide physical address. Each channel has a low page byte and a high page byte. Software reaches them through two small 8-slot port windows, one for low pages and one for high pages. The slot number maps to a channel through a fixed, non-linear table, and the four unmapped slots are dead.

The high-page window only exists when `hi_en` is set. When `hi_en` is clear, that window neither stores nor returns data, and the high page is left out of the address.

On the transfer side, the surrounding controller supplies three things: the channel, its current 16-bit address and a transfer position. The block returns the physical address for that position. In up-counting mode the position is added to the composed base. In down-counting mode the start of a block of `blk_len` bytes is found by subtracting both the position and the length from the base.

Top module: `dma_page_addr_gen`

## Requirements
- R1: Slot `port_off` maps to channels as follows: 7 to channel 0, 3 to channel 1, 1 to channel 2, 2 to channel 3. A write with `wr_en` high stores `wr_data` in the mapped channel's register at the next rising clock edge.
- R2: A write to slot 0, 4, 5 or 6 of either window changes no register.
- R3: `rd_data` is 0 whenever `port_off` is 0, 4, 5 or 6.
- R4: With `hi_en`=1 and `sel_hi`=1, writes and reads go to the high page register of the mapped channel, and all 8 bits read back. The low page window (`sel_hi`=0) is a separate register set.
- R5: With `hi_en`=0, high-window writes are dropped and high-window reads return 0. The high page also contributes zeros to `phys_addr`.
- R6: The 31-bit base is laid out as follows: bits 30:24 hold the high page bits 6:0, bits 23:16 hold the low page and bits 15:0 hold `cur_addr`. With `count_down`=0, `phys_addr` = base + `xfer_pos`, taken modulo 2^31.
- R7: With `count_down`=1, `phys_addr` = base − `xfer_pos` − `blk_len`, taken modulo 2^31.
- R8: After reset, every page and high page register reads 0.
- R9: Bit 7 of a high page register never affects `phys_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_en | input | 1 | Enables the high-page window and its address contribution |
| wr_en | input | 1 | Register write strobe |
| sel_hi | input | 1 | 1 selects the high-page window, 0 the low-page window |
| port_off | input | 3 | Slot within the selected window |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for the addressed slot (combinational) |
| chan | input | 2 | Channel whose address is composed |
| count_down | input | 1 | Direction: 1 = down-counting |
| cur_addr | input | 16 | Channel's current address |
| xfer_pos | input | 16 | Transfer position |
| blk_len | input | 16 | Block length, used in down-counting mode |
| phys_addr | output | 31 | Composed physical address |

## Verification
Distinct byte values are written to every slot of both windows. Read-back then shows whether the scrambled slot-to-channel table is right and whether the two windows share storage. Dead slots are written with all-ones and checked by reading the live slots, which catches a decode that aliases onto a real channel. Address composition is tried with positions that carry out of the low 16 bits, and with down-counting underflow past zero. This separates a correct modular sum from a simple bit-OR. A high page with bit 7 set tells whether the 7-bit limit is applied.

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen #(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16,
  localparam int NCH   = 4,
  localparam int HI_W  = PAGE_W - 1,
  localparam int AW    = HI_W + PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_en,
  input  logic              wr_en,
  input  logic              sel_hi,
  input  logic [2:0]        port_off,
  input  logic [PAGE_W-1:0] wr_data,
  output logic [PAGE_W-1:0] rd_data,
  input  logic [1:0]        chan,
  input  logic              count_down,
  input  logic [OFS_W-1:0]  cur_addr,
  input  logic [OFS_W-1:0]  xfer_pos,
  input  logic [OFS_W-1:0]  blk_len,
  output logic [AW-1:0]     phys_addr
);

  logic [NCH-1:0][PAGE_W-1:0] page_q, hpage_q;
  logic       slot_ok;
  logic [1:0] slot_ch;

  always_comb begin
    slot_ok = 1'b1;
    slot_ch = 2'd0;
    case (port_off)
      3'd7: slot_ch = 2'd0;
      3'd3: slot_ch = 2'd1;
      3'd1: slot_ch = 2'd2;
      3'd2: slot_ch = 2'd3;
      default: slot_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      hpage_q <= '0;
    end else if (wr_en && slot_ok) begin
      if (!sel_hi)    page_q[slot_ch]  <= wr_data;
      else if (hi_en) hpage_q[slot_ch] <= wr_data;
    end
  end

  assign rd_data = !slot_ok ? '0 :
                   !sel_hi  ? page_q[slot_ch] :
                   hi_en    ? hpage_q[slot_ch] : '0;

  logic [HI_W-1:0] hi_bits;
  logic [AW-1:0]   base;

  assign hi_bits   = hi_en ? hpage_q[chan][HI_W-1:0] : '0;
  assign base      = {hi_bits, page_q[chan], cur_addr};
  assign phys_addr = count_down ? base - AW'(xfer_pos) - AW'(blk_len)
                                : base + AW'(xfer_pos);

endmodule

// File: rtl/page_addr_chk.sv
module page_addr_chk #(
  parameter int PAGE_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   hi_en,
  input logic                   wr_en,
  input logic                   sel_hi,
  input logic [2:0]             port_off,
  input logic [PAGE_W-1:0]      wr_data,
  input logic [PAGE_W-1:0]      rd_data,
  input logic [3:0][PAGE_W-1:0] page_q,
  input logic [3:0][PAGE_W-1:0] hpage_q
);

  logic dead_slot;
  assign dead_slot = (port_off == 3'd0) || (port_off == 3'd4) ||
                     (port_off == 3'd5) || (port_off == 3'd6);

  assert_ch0_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_hi && port_off == 3'd7) |=> page_q[0] == $past(wr_data));

  assert_dead_wr_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dead_slot) |=> ($stable(page_q) && $stable(hpage_q)));

  assert_dead_rd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dead_slot |-> rd_data == '0);

  assert_hi_off_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_en && sel_hi) |-> rd_data == '0);

  assert_hi_off_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_hi && !hi_en) |=> $stable(hpage_q));

  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (page_q == '0 && hpage_q == '0));

endmodule

bind dma_page_addr_gen page_addr_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hi_en(hi_en), .wr_en(wr_en), .sel_hi(sel_hi),
  .port_off(port_off), .wr_data(wr_data), .rd_data(rd_data),
  .page_q(page_q), .hpage_q(hpage_q)
);

// File: tb/tb_dma_page_addr_gen.sv
module tb_dma_page_addr_gen;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        hi_en = 1'b1, wr_en = 1'b0, sel_hi = 1'b0, count_down = 1'b0;
  logic [2:0]  port_off = 3'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [7:0]  rd_data;
  logic [1:0]  chan = 2'd0;
  logic [15:0] cur_addr = 16'd0, xfer_pos = 16'd0, blk_len = 16'd0;
  logic [30:0] phys_addr;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_pg [4];
  logic [7:0] m_hp [4];

  always #10 clk = ~clk;

  dma_page_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .hi_en(hi_en), .wr_en(wr_en), .sel_hi(sel_hi),
    .port_off(port_off), .wr_data(wr_data), .rd_data(rd_data), .chan(chan),
    .count_down(count_down), .cur_addr(cur_addr), .xfer_pos(xfer_pos),
    .blk_len(blk_len), .phys_addr(phys_addr)
  );

  function automatic int slot_map(input logic [2:0] o);
    case (o)
      3'd7: return 0;
      3'd3: return 1;
      3'd1: return 2;
      3'd2: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic hi, input logic [2:0] off, input logic [7:0] d);
    int c;
    @(negedge clk);
    sel_hi = hi; port_off = off; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    c = slot_map(off);
    if (c >= 0) begin
      if (!hi) m_pg[c] = d;
      else if (hi_en) m_hp[c] = d;
    end
  endtask

  task automatic rd_chk(input string tag, input logic hi, input logic [2:0] off);
    int c;
    logic [7:0] e;
    @(negedge clk);
    sel_hi = hi; port_off = off;
    #2;
    c = slot_map(off);
    if (c < 0) e = 8'd0;
    else if (!hi) e = m_pg[c];
    else e = hi_en ? m_hp[c] : 8'd0;
    check(tag, {24'd0, rd_data}, {24'd0, e});
  endtask

  task automatic addr_chk(input string tag, input logic [1:0] ch, input logic dn,
                          input logic [15:0] cur, input logic [15:0] pos, input logic [15:0] len);
    logic [30:0] b, e;
    @(negedge clk);
    chan = ch; count_down = dn; cur_addr = cur; xfer_pos = pos; blk_len = len;
    #2;
    b = {(hi_en ? m_hp[ch][6:0] : 7'd0), m_pg[ch], cur};
    e = dn ? b - 31'(pos) - 31'(len) : b + 31'(pos);
    check(tag, {1'b0, phys_addr}, {1'b0, e});
  endtask

  task automatic t_reset;
    for (int o = 0; o < 8; o++) begin
      rd_chk("R8 low page after reset", 1'b0, 3'(o));
      rd_chk("R8 high page after reset", 1'b1, 3'(o));
    end
  endtask

  task automatic t_map;
    do_wr(1'b0, 3'd7, 8'h10);
    do_wr(1'b0, 3'd3, 8'h21);
    do_wr(1'b0, 3'd1, 8'h32);
    do_wr(1'b0, 3'd2, 8'h43);
    for (int o = 0; o < 8; o++) rd_chk("R1 slot readback", 1'b0, 3'(o));
    for (int c = 0; c < 4; c++) addr_chk("R1 page to channel", 2'(c), 1'b0, 16'h0000, 16'h0000, 16'h0);
  endtask

  task automatic t_dead;
    do_wr(1'b0, 3'd0, 8'hFF);
    do_wr(1'b0, 3'd4, 8'hFF);
    do_wr(1'b1, 3'd5, 8'hFF);
    do_wr(1'b1, 3'd6, 8'hFF);
    foreach (m_pg[c]) addr_chk("R2 dead slot write dropped", 2'(c), 1'b0, 16'h1234, 16'h0, 16'h0);
    for (int o = 0; o < 8; o++) rd_chk("R2 live slots unchanged", 1'b0, 3'(o));
    rd_chk("R3 dead slot reads zero", 1'b0, 3'd4);
    rd_chk("R3 dead slot reads zero hi", 1'b1, 3'd0);
  endtask

  task automatic t_high;
    hi_en = 1'b1;
    do_wr(1'b1, 3'd7, 8'hA5);
    do_wr(1'b1, 3'd3, 8'h7E);
    do_wr(1'b1, 3'd1, 8'h81);
    do_wr(1'b1, 3'd2, 8'h03);
    for (int o = 0; o < 8; o++) rd_chk("R4 high window readback", 1'b1, 3'(o));
    for (int o = 0; o < 8; o++) rd_chk("R4 low window separate", 1'b0, 3'(o));
    addr_chk("R9 bit7 masked ch0", 2'd0, 1'b0, 16'hBEEF, 16'h0, 16'h0);
    addr_chk("R9 bit7 masked ch2", 2'd2, 1'b0, 16'h0001, 16'h0, 16'h0);
  endtask

  task automatic t_hi_off;
    hi_en = 1'b0;
    rd_chk("R5 high read zero when disabled", 1'b1, 3'd7);
    do_wr(1'b1, 3'd7, 8'h33);
    addr_chk("R5 no high contribution", 2'd0, 1'b0, 16'h4000, 16'h0, 16'h0);
    addr_chk("R5 no high contribution ch1", 2'd1, 1'b1, 16'h4000, 16'h10, 16'h10);
    hi_en = 1'b1;
    rd_chk("R5 disabled write dropped", 1'b1, 3'd7);
  endtask

  task automatic t_inc;
    addr_chk("R6 plain add", 2'd1, 1'b0, 16'h1000, 16'h0020, 16'h0);
    addr_chk("R6 carry into page", 2'd3, 1'b0, 16'hFFF0, 16'h0020, 16'h0);
    addr_chk("R6 length ignored upward", 2'd0, 1'b0, 16'h8000, 16'h8000, 16'hFFFF);
  endtask

  task automatic t_dec;
    addr_chk("R7 down simple", 2'd1, 1'b1, 16'h1000, 16'h0010, 16'h0040);
    addr_chk("R7 borrow from page", 2'd2, 1'b1, 16'h0008, 16'h0010, 16'h0020);
    do_wr(1'b0, 3'd7, 8'h00);
    do_wr(1'b1, 3'd7, 8'h00);
    addr_chk("R7 wrap below zero", 2'd0, 1'b1, 16'h0004, 16'h0004, 16'h0001);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    foreach (m_pg[c]) begin m_pg[c] = 8'd0; m_hp[c] = 8'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_dead();
    t_high();
    t_hi_off();
    t_inc();
    t_dec();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule